// File: doc/BRIEF.md
# Three-wire serial RAM slave

This block is the device-side logic of a 128-byte read/write memory that a host reaches over three wires: a serial clock, a cycle-enable line and one bidirectional data line. All three wires are oversampled by the system clock. Each is passed through a two-stage synchronizer, and the serial clock is edge-detected inside the system clock domain. The system clock must run at least eight times faster than the fastest serial clock, which is 4 MHz.

A transfer opens when the cycle-enable line rises. The host first shifts in a 24-bit command word, least significant bit of each byte first. The block checks the word against fixed patterns. If the word is valid, the block moves one byte, or a 128-byte burst, into or out of an internal register array. A malformed command locks the block out until the enable line falls and rises again. Read data leaves on the data line through an output-enable, and a pad model outside the block resolves the tri-state.

The serial link has no back-pressure: the host paces every bit with its clock. For that reason the block has no valid/ready handshake. Every serial clock edge that arrives while the enable line is high is acted on, or deliberately ignored.

Top module: `serial_ram_slave`

## Requirements
- R1: After system reset the data output-enable is 0 and every array byte reads back as 0x00.
- R2: After the enable line rises, the block samples the data line on each of the next 24 rising serial clock edges and assembles three bytes, each least significant bit first. The first byte must equal 0x9D (binary 1001_1101) to select a read or 0x62 (binary 0110_0010) to select a write. Any other value aborts the cycle.
- R3: In the second byte, bits 6..0 are the address and bit 7 must be 0. If bit 7 is 1, the cycle aborts.
- R4: In the third byte, bits 6..0 must all be 0 and bit 7 is the burst flag. An abort from R2, R3 or R4 locks the block out: no write happens and the data line is not driven until the enable line goes low and then high again, even if a valid command follows without that.
- R5: In a single-byte write, the next 8 rising edges sample the data byte least significant bit first. The byte is stored after the 8th bit, and any later edges in the same cycle change nothing.
- R6: In a read, each bit appears on the data line after a falling serial clock edge, least significant bit first. The output-enable is 1 while those bits are driven.
- R7: Address 0 together with the burst flag selects a burst. Successive bytes go to, or come from, addresses 0, 1, 2 and so on, and the address wraps from 127 back to 0.
- R8: The burst flag together with a non-zero address gives a single-byte transfer at that address, and the following address is left untouched.
- R9: When the enable line is low, the output-enable drops to 0 and the transfer stops. A write byte that is only partly shifted in is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low system reset |
| ser_clk_i | input | 1 | Serial clock from the host (asynchronous) |
| ser_rst_i | input | 1 | Cycle enable from the host, active high (asynchronous) |
| ser_dq_i | input | 1 | Value seen on the data pad |
| ser_dq_o | output | 1 | Data bit the block drives onto the pad |
| ser_dq_oe | output | 1 | Output-enable for the data pad |

## Verification
The assertions in the controller check, on every cycle, the rules that involve only the block's own state. The output-enable is seen only during the data phase of a read and drops one cycle after the synchronized enable falls. A lockout state stays put while the enable is high, a single-byte store ends the transfer, and the burst address wraps from 127 to 0. Other behaviour only shows when whole scenarios run. That covers the bit order of command and data, the exact command patterns, the effect an aborted or truncated cycle has on stored contents, and burst ordering across the wrap. The bench covers these with a scoreboard image of the array and reads each result back over the serial link.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned SRS_DW    = 8;
  localparam int unsigned SRS_DEPTH = 128;
  localparam int unsigned SRS_CMD_BYTES = 3;

  localparam logic [7:0] SRS_OP_READ  = 8'b1001_1101;
  localparam logic [7:0] SRS_OP_WRITE = 8'b0110_0010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_LOCK = 2'd3
  } srs_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/srs_edge.sv
module srs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/srs_mem.sv
module srs_mem #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (we_i) begin
      cell_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[addr_i];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned BW   = $clog2(DW),
  localparam int unsigned CMD_W = SRS_CMD_BYTES * DW,
  localparam int unsigned CW   = $clog2(CMD_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_en,
  input  logic          s_dq,
  input  logic          s_rise,
  input  logic          s_fall,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dq_o,
  output logic          dq_oe
);
  srs_state_e    state_q;
  logic [CMD_W-1:0] cmd_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [AW-1:0] addr_q;
  logic          rd_q, burst_q;
  logic [DW-1:0] wbuf_q;

  logic [CMD_W-1:0] cmd_next;
  logic [DW-1:0] op_b, adr_b, flg_b;
  logic          cmd_ok, last_bit;

  assign cmd_next = {s_dq, cmd_q[CMD_W-1:1]};
  assign op_b     = cmd_next[DW-1:0];
  assign adr_b    = cmd_next[2*DW-1:DW];
  assign flg_b    = cmd_next[3*DW-1:2*DW];
  assign cmd_ok   = ((op_b == SRS_OP_READ) || (op_b == SRS_OP_WRITE))
                    && !adr_b[DW-1] && (flg_b[DW-2:0] == '0);
  assign last_bit = (bit_q == BW'(DW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      wbuf_q  <= '0;
      dq_o    <= 1'b0;
      dq_oe   <= 1'b0;
    end else if (!s_en) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      dq_oe   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_CMD;
          cnt_q   <= '0;
        end
        ST_CMD: if (s_rise) begin
          cmd_q <= cmd_next;
          if (cnt_q == CW'(CMD_W-1)) begin
            if (cmd_ok) begin
              state_q <= ST_DATA;
              addr_q  <= adr_b[AW-1:0];
              rd_q    <= (op_b == SRS_OP_READ);
              burst_q <= flg_b[DW-1] && (adr_b[AW-1:0] == '0);
              bit_q   <= '0;
            end else begin
              state_q <= ST_LOCK;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (rd_q && s_fall) begin
            dq_o  <= mem_rdata[bit_q];
            dq_oe <= 1'b1;
          end
          if (s_rise) begin
            if (!rd_q) wbuf_q <= {s_dq, wbuf_q[DW-1:1]};
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              if (burst_q) begin
                addr_q <= addr_q + 1'b1;
              end else begin
                state_q <= ST_LOCK;
                dq_oe   <= 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_we    = (state_q == ST_DATA) && !rd_q && s_rise && last_bit && s_en;
  assign mem_addr  = addr_q;
  assign mem_wdata = {s_dq, wbuf_q[DW-1:1]};

  // R6: the pad is driven only during the data phase of a read
  p_oe_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (state_q == ST_DATA && rd_q));

  // R9: enable low releases the pad on the next cycle
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> !dq_oe);

  // R4: lockout holds while the enable stays high
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && s_en) |=> (state_q == ST_LOCK));

  // R5: a single-byte store closes the transfer
  p_single_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !burst_q) |=> (state_q == ST_LOCK || state_q == ST_IDLE));

  // R7: burst address wraps from the top back to zero
  p_burst_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && burst_q && s_en && s_rise && last_bit
     && addr_q == AW'(DEPTH-1)) |=> (addr_q == '0));
endmodule

// File: rtl/serial_ram_slave.sv
module serial_ram_slave
  import srs_pkg::*;
#(
  parameter int unsigned DEPTH = SRS_DEPTH,
  parameter int unsigned DW    = SRS_DW,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk_i,
  input  logic ser_rst_i,
  input  logic ser_dq_i,
  output logic ser_dq_o,
  output logic ser_dq_oe
);
  logic [2:0] pins_s;
  logic s_rise, s_fall;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  srs_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_dq_i, ser_rst_i, ser_clk_i}),
    .sync_o(pins_s)
  );

  srs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pins_s[0]),
    .rise_o(s_rise), .fall_o(s_fall)
  );

  srs_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_en(pins_s[1]), .s_dq(pins_s[2]),
    .s_rise(s_rise), .s_fall(s_fall),
    .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dq_o(ser_dq_o), .dq_oe(ser_dq_oe)
  );

  srs_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );
endmodule

// File: tb/serial_ram_slave_tb_top.sv
module serial_ram_slave_tb_top;
  localparam int H = 6;
  localparam logic [7:0] RD = 8'h9D;
  localparam logic [7:0] WR = 8'h62;
  localparam logic [14:0] VEC [8] = '{
    {7'd1, 8'h5A}, {7'd2, 8'hA5}, {7'd33, 8'hFF}, {7'd64, 8'h01},
    {7'd127, 8'h80}, {7'd77, 8'h3C}, {7'd90, 8'hC3}, {7'd15, 8'h96}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, sclk = 1'b1, srst = 1'b0, host_dq = 1'b0;
  wire  dq_o, dq_oe;
  wire  pad = dq_oe ? dq_o : host_dq;

  int checks = 0, errors = 0;
  logic [7:0] model [128];

  serial_ram_slave dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_rst_i(srst),
    .ser_dq_i(pad), .ser_dq_o(dq_o), .ser_dq_oe(dq_oe));

  task automatic hw(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(logic b);
    sclk = 1'b0; host_dq = b; hw(H);
    sclk = 1'b1; hw(H);
  endtask

  task automatic sbyte(logic [7:0] v);
    for (int i = 0; i < 8; i++) sbit(v[i]);
  endtask

  task automatic rbyte(output logic [7:0] v, inout logic oe_all);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; hw(H);
      v[i] = pad; oe_all &= dq_oe;
      sclk = 1'b1; hw(H);
    end
  endtask

  task automatic open_c(); sclk = 1'b1; srst = 1'b1; hw(H); endtask
  task automatic close_c(); srst = 1'b0; hw(H); endtask

  task automatic cmd(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    sbyte(a); sbyte(b); sbyte(c);
  endtask

  task automatic wr1(logic [6:0] a, logic [7:0] d);
    open_c(); cmd(WR, {1'b0, a}, 8'h00); sbyte(d); close_c();
    model[a] = d;
  endtask

  task automatic rd1(logic [6:0] a, output logic [7:0] v, output logic oe_all);
    oe_all = 1'b1;
    open_c(); cmd(RD, {1'b0, a}, 8'h00); rbyte(v, oe_all); close_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic oe;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    hw(4); rst_n = 1'b1; hw(4);

    // R1: reset state
    chk(dq_oe == 1'b0, "R1 oe after reset", dq_oe, 0);
    rd1(7'd100, v, oe);
    chk(v == 8'h00, "R1 reset contents", v, 0);

    // R5/R6: table of single-byte writes, then read-back
    for (int k = 0; k < 8; k++) wr1(VEC[k][14:8], VEC[k][7:0]);
    for (int k = 0; k < 8; k++) begin
      rd1(VEC[k][14:8], v, oe);
      chk(v == VEC[k][7:0], "R5 R6 table readback", v, VEC[k][7:0]);
      chk(oe == 1'b1, "R6 oe during read", oe, 1);
    end

    wr1(7'd40, 8'h11);
    // R2: bad opcode locks out, valid command after it is ignored too
    open_c(); cmd(8'h63, 8'd40, 8'h00); sbyte(8'hEE);
    cmd(WR, 8'd40, 8'h00); sbyte(8'hEE); close_c();
    rd1(7'd40, v, oe);
    chk(v == 8'h11, "R2 bad opcode no write", v, 8'h11);
    // R3: address bit 7 set
    open_c(); cmd(WR, 8'h80 | 8'd40, 8'h00); sbyte(8'hEE); close_c();
    rd1(7'd40, v, oe);
    chk(v == 8'h11, "R3 addr bit7 abort", v, 8'h11);
    // R4: reserved bit in third byte
    open_c(); cmd(WR, 8'd40, 8'h08); sbyte(8'hEE); close_c();
    rd1(7'd40, v, oe);
    chk(v == 8'h11, "R4 reserved bit abort", v, 8'h11);
    oe = 1'b0;
    open_c(); cmd(RD, 8'd40, 8'h01);
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0; hw(H); oe |= dq_oe; sclk = 1'b1; hw(H);
    end
    close_c();
    chk(oe == 1'b0, "R4 locked read never drives", oe, 0);

    // R5: extra clocks after single-byte write ignored
    open_c(); cmd(WR, 8'd20, 8'h00); sbyte(8'h3C); sbyte(8'hC3); close_c();
    model[20] = 8'h3C;
    rd1(7'd20, v, oe);
    chk(v == 8'h3C, "R5 stored byte", v, 8'h3C);
    rd1(7'd21, v, oe);
    chk(v == model[21], "R5 next addr untouched", v, model[21]);

    // R9: partial write discarded, pad released
    open_c(); cmd(WR, 8'd20, 8'h00);
    for (int i = 0; i < 4; i++) sbit(1'b1);
    close_c();
    chk(dq_oe == 1'b0, "R9 oe low after close", dq_oe, 0);
    rd1(7'd20, v, oe);
    chk(v == 8'h3C, "R9 partial write dropped", v, 8'h3C);
    open_c(); cmd(RD, 8'd20, 8'h00);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; hw(H); sclk = 1'b1; hw(H);
    end
    chk(dq_oe == 1'b1, "R9 oe mid read", dq_oe, 1);
    close_c();
    chk(dq_oe == 1'b0, "R9 oe released", dq_oe, 0);

    // R8: burst flag with non-zero address is single byte
    open_c(); cmd(WR, 8'd9, 8'h80); sbyte(8'h77); sbyte(8'h88); close_c();
    model[9] = 8'h77;
    rd1(7'd9, v, oe);
    chk(v == 8'h77, "R8 flagged single byte", v, 8'h77);
    rd1(7'd10, v, oe);
    chk(v == model[10], "R8 neighbour untouched", v, model[10]);

    // R7: burst write all 128, burst read 130 with wrap
    open_c(); cmd(WR, 8'h00, 8'h80);
    for (int i = 0; i < 128; i++) begin
      sbyte(8'(i * 5 + 3)); model[i] = 8'(i * 5 + 3);
    end
    close_c();
    oe = 1'b1;
    open_c(); cmd(RD, 8'h00, 8'h80);
    for (int i = 0; i < 130; i++) begin
      rbyte(v, oe);
      chk(v == model[i % 128], "R7 burst data", v, model[i % 128]);
    end
    close_c();
    chk(oe == 1'b1, "R7 oe through burst", oe, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule